// File: doc/BRIEF.md
# Single-Scan Table-Driven Sequential Machine

This block is a clocked sequential machine whose state is split in two parts: a small index register (the head) and a row of single-bit storage cells, one cell for every value the head may legally hold. In any cycle only the cell selected by the head can be seen or changed. A programmable rule table decides each step. It reads the serial input bit, the head value and the bit of the selected cell. From these it gives the output bit, the value to store back into the selected cell, and the head value for the next step.

The rule table is filled through a synchronous configuration port while the machine is paused. When the run enable is raised, the machine takes one step per clock. The head and the whole cell row are brought out as debug views. A sticky fault flag reports any rule that names a head value outside the cell range. The machine can be used as a compact tape-style controller, where a large amount of one-bit state is reached through a narrow index instead of being wired in parallel.

Top module: `scan_machine`

## Requirements
- R1: While `rst` is high at a clock edge, the head, every cell, `dout` and `fault` are all cleared to 0 by that edge.
- R2: A step never changes any cell other than the one that the head selected before the step.
- R3: In a step, the selected cell takes the write bit of the rule entry. The write bit is bit 1 of the entry.
- R4: In a step whose rule names a next head below CELLS, the head takes that value at the same edge. The next head sits in bits [SW+1:2] of the entry.
- R5: In a step, `dout` shows the output bit of the rule entry one clock after the inputs were sampled. The output bit is bit 0 of the entry.
- R6: While `run_en` is low, the head, all cells and `dout` hold their values, whatever `din` does.
- R7: A configuration write is taken only when `run_en` is low. A write offered while `run_en` is high has no effect on later steps.
- R8: A rule that names a next head at or above CELLS leaves the head unchanged and sets `fault`. `fault` stays set until reset, and the head never holds a value at or above CELLS.
- R9: The rule table is indexed by the concatenation {head, din, selected cell bit}, with the cell bit as the LSB. Entries are packed as {next head, write bit, output bit}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable: one step per clock when high; configuration allowed when low |
| din | input | 1 | Serial input bit |
| cfg_we | input | 1 | Rule table write strobe |
| cfg_addr | input | SW+2 | Rule index {head, din, cell bit} |
| cfg_data | input | SW+2 | Rule entry {next head, write bit, output bit} |
| dout | output | 1 | Registered output bit |
| head_q | output | SW | Debug view of the head register |
| cells_q | output | CELLS | Debug view of the cell row, bit i = cell i |
| fault | output | 1 | Sticky flag for an out-of-range next head |

SW = max(1, ceil(log2 CELLS)).

## Verification
The bench builds the block with CELLS = 6. This gives a 3-bit head in which the codes 6 and 7 are illegal, so the out-of-range path, the head hold and the sticky fault can actually be reached. With the default power-of-two size, every code is a legal cell and those paths cannot be exercised. Six cells still make a cell row small enough that random rule tables walk the head over every cell many times. This drives writes, hold phases, ignored configuration attempts and a reset in the middle of a run.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Width of an index able to address n items, never below one bit.
  function automatic int idx_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/scan_rule_table.sv
module scan_rule_table #(
  parameter int AW = 5,
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/scan_cell_array.sv
module scan_cell_array #(
  parameter int CELLS = 8,
  parameter int SW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SW-1:0]    addr,
  input  logic             wbit,
  output logic             rbit,
  output logic [CELLS-1:0] cells_q
);
  always_ff @(posedge clk) begin
    if (rst) cells_q <= '0;
    else if (we) cells_q[addr] <= wbit;
  end

  assign rbit = cells_q[addr];

  // R2: untouched cells keep their value
  a_r2_only_scanned: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we)) |->
      (((cells_q ^ $past(cells_q)) & ~(CELLS'(1) << $past(addr))) == '0));

  // R3: scanned cell holds the written bit
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we)) |-> (cells_q[$past(addr)] == $past(wbit)));
endmodule

// File: rtl/scan_head_reg.sv
module scan_head_reg #(
  parameter int CELLS = 8,
  parameter int SW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [SW-1:0] next,
  output logic [SW-1:0] head_q,
  output logic          fault
);
  localparam logic [SW:0] LIMIT = (SW+1)'(CELLS);

  logic legal;
  assign legal = ({1'b0, next} < LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      fault  <= 1'b0;
    end else if (step) begin
      if (legal) head_q <= next;
      else       fault  <= 1'b1;
    end
  end

  // R4: a legal next value is taken
  a_r4_head_follows: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(step) && $past(legal)) |-> (head_q == $past(next)));

  // R8: illegal next holds the head, fault is sticky, head stays in range
  a_r8_illegal_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(step) && !$past(legal)) |-> ($stable(head_q) && fault));

  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fault)) |-> fault);

  a_r8_head_in_range: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, head_q} < LIMIT));
endmodule

// File: rtl/scan_machine.sv
module scan_machine #(
  parameter int CELLS = 8,
  localparam int SW   = scan_pkg::idx_width(CELLS),
  localparam int AW   = SW + 2,
  localparam int DW   = SW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             din,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_data,
  output logic             dout,
  output logic [SW-1:0]    head_q,
  output logic [CELLS-1:0] cells_q,
  output logic             fault
);
  logic          cell_bit;
  logic [AW-1:0] rule_idx;
  logic [DW-1:0] rule;
  logic [SW-1:0] rule_next;
  logic          rule_wbit;
  logic          rule_out;
  logic          cfg_take;

  assign cfg_take  = cfg_we && !run_en;
  assign rule_idx  = {head_q, din, cell_bit};
  assign rule_next = rule[DW-1:2];
  assign rule_wbit = rule[1];
  assign rule_out  = rule[0];

  scan_rule_table #(.AW(AW), .DW(DW)) u_table (
    .clk   (clk),
    .we    (cfg_take),
    .waddr (cfg_addr),
    .wdata (cfg_data),
    .raddr (rule_idx),
    .rdata (rule)
  );

  scan_cell_array #(.CELLS(CELLS), .SW(SW)) u_cells (
    .clk     (clk),
    .rst     (rst),
    .we      (run_en),
    .addr    (head_q),
    .wbit    (rule_wbit),
    .rbit    (cell_bit),
    .cells_q (cells_q)
  );

  scan_head_reg #(.CELLS(CELLS), .SW(SW)) u_head (
    .clk    (clk),
    .rst    (rst),
    .step   (run_en),
    .next   (rule_next),
    .head_q (head_q),
    .fault  (fault)
  );

  always_ff @(posedge clk) begin
    if (rst)         dout <= 1'b0;
    else if (run_en) dout <= rule_out;
  end

  // R5: output is the table output bit of the previous step
  a_r5_dout_registered: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(run_en)) |-> (dout == $past(rule_out)));

  // R6: paused machine holds all state
  a_r6_pause_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(run_en)) |->
      ($stable(head_q) && $stable(cells_q) && $stable(dout)));

  // R1: reset leaves everything clear
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (head_q == '0 && cells_q == '0 && !dout && !fault));
endmodule

// File: tb/sim_scan_machine.sv
module sim_scan_machine;
  localparam int N  = 6;
  localparam int SW = 3;
  localparam int AW = SW + 2;
  localparam int DW = SW + 2;
  localparam int TS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run_en = 1'b0;
  logic          din = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_data = '0;
  logic          dout;
  logic [SW-1:0] head_q;
  logic [N-1:0]  cells_q;
  logic          fault;

  scan_machine #(.CELLS(N)) u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .din(din),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .dout(dout), .head_q(head_q), .cells_q(cells_q), .fault(fault)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int m_head = 0;
  bit [N-1:0] m_cells = '0;
  bit m_dout = 0, m_fault = 0;
  int m_tab [TS];
  bit finished = 0;

  task automatic cmp(string ph, string sig, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", ph, sig, act, exp);
    end
  endtask

  // one clock: model update from the driven inputs, then compare
  task automatic tick(string ph);
    int idx, e, nx;
    @(posedge clk);
    if (rst) begin
      m_head = 0; m_cells = '0; m_dout = 0; m_fault = 0;
    end else begin
      if (cfg_we && !run_en) m_tab[cfg_addr] = int'(cfg_data);
      if (run_en) begin
        idx = m_head * 4 + int'(din) * 2 + int'(m_cells[m_head]);
        e   = m_tab[idx];
        nx  = e >> 2;
        m_cells[m_head] = e[1];
        m_dout = e[0];
        if (nx < N) m_head = nx;
        else        m_fault = 1;
      end
    end
    #1;
    cmp(ph, "R4 head", int'(head_q), m_head);
    cmp(ph, "R2/R3 cells", int'(cells_q), int'(m_cells));
    cmp(ph, "R5 dout", int'(dout), int'(m_dout));
    cmp(ph, "R8 fault", int'(fault), int'(m_fault));
  endtask

  // fill the table; bad_pct percent of entries name an illegal head
  task automatic load(int bad_pct);
    run_en = 0;
    for (int a = 0; a < TS; a++) begin
      int nx;
      nx = ($urandom % 100 < bad_pct) ? (N + ($urandom % ((1 << SW) - N)))
                                      : ($urandom % N);
      cfg_we = 1; cfg_addr = AW'(a);
      cfg_data = {SW'(nx), 1'($urandom), 1'($urandom)};
      tick("R9 load");
    end
    cfg_we = 0;
  endtask

  task automatic run(int n, string ph, bit try_cfg);
    for (int i = 0; i < n; i++) begin
      run_en = 1; din = 1'($urandom);
      cfg_we = try_cfg; cfg_addr = AW'($urandom);
      cfg_data = DW'($urandom);
      tick(ph);
    end
    cfg_we = 0;
  endtask

  initial begin
    repeat (4) tick("R1");
    rst = 0;
    load(0);
    run(400, "R9 run", 0);
    for (int i = 0; i < 20; i++) begin
      run_en = 0; din = 1'($urandom);
      tick("R6");
    end
    run(300, "R7", 1);
    run(100, "R7 after", 0);
    load(25);
    run(300, "R8", 0);
    rst = 1; run_en = 0;
    repeat (3) tick("R1 again");
    rst = 0;
    load(0);
    run(200, "R3", 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule